// File: doc/BRIEF.md
# Dual-channel test pattern interleaver

This block takes two 12-bit pixel streams, one for the even channel and one for the odd channel, that arrive together once per pixel period. It turns them into a single 12-bit word stream at twice the pixel rate. The block runs on the word-rate clock. A pixel strobe, high for one cycle in every two, marks when the channel pair is taken in. Of the two words in each pair, either channel can be sent first.

For bring-up and board test, a test mode replaces the channel data with an internally generated pattern. The stripe pattern alternates between each channel's black level raised by 128 and the plain black level. The gradation pattern is a code that climbs slowly from 1 to the full-scale value. Both patterns have a run length that can be set. The output drivers are modelled as a valid flag plus a forced-zero word. A monitor option replaces the lowest output bit with the internal converter clock.

Top module: `afe_dual_interleaver`

## Requirements
- R1: With the order bit `odd_first` = 0, the word on `out_word` in the cycle after a cycle with `pix_stb` = 1 is the even word taken in at that strobe. In the following cycle it is the odd word.
- R2: With `odd_first` = 1, the odd word comes out first (one cycle after the strobe) and the even word second.
- R3: Test mode (`test_en` = 1) is off after reset. While it is on, both channel words are replaced by the pattern, and the values on `even_word`/`odd_word` have no effect on the output.
- R4: `pat_sel` = 0 selects the gradation pattern and `pat_sel` = 1 selects the stripe pattern.
- R5: The stripe value for a channel is 2×clamp+128 for a run of pixels, then 2×clamp for a run of the same length, and so on. The clamp is the 8-bit `clamp_even`/`clamp_odd`. `pat_interval` codes 0,1,2,3 give runs of 8,16,32,64 pixels. The first run after test mode is entered is the raised one.
- R6: The gradation code, the same on both channels, starts at 1 when test mode is entered. It holds for 2,4,8,16 pixels (`pat_interval` codes 0 to 3), then increases by 1. After 4095 it goes back to 1.
- R7: With `oe_n` = 1, `out_valid` is 0 and `out_word` is all zeros. With `oe_n` = 0, `out_valid` is 1.
- R8: With `mon_sel` = 1, bit 0 of `out_word` shows the converter clock in place of data bit 0. The converter clock is 1 in the cycle that carries the first word of a pair and 0 in the cycle that carries the second. Bits 11..1 are unchanged.
- R9: During and right after reset, `out_word` is zero and the converter clock is 0.
- R10: Turning test mode off for any length of time restarts the pattern from its initial state (count zero, raised stripe, gradation code 1) when test mode is turned on again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word-rate clock (twice the pixel rate) |
| rst_n | input | 1 | Asynchronous reset, active low |
| pix_stb | input | 1 | Pixel strobe: take in the channel pair this cycle |
| even_word | input | 12 | Even channel converter word |
| odd_word | input | 12 | Odd channel converter word |
| odd_first | input | 1 | 0 = even then odd, 1 = odd then even |
| test_en | input | 1 | Replace data with the test pattern |
| pat_sel | input | 1 | 0 = gradation, 1 = stripe |
| pat_interval | input | 2 | Run length code for the pattern |
| clamp_even | input | 8 | Even channel black clamp code (level = 2×code) |
| clamp_odd | input | 8 | Odd channel black clamp code (level = 2×code) |
| oe_n | input | 1 | Output enable, active low |
| mon_sel | input | 1 | Put the converter clock on bit 0 |
| out_word | output | 12 | Interleaved output word, straight binary |
| out_valid | output | 1 | Output is driven (not high impedance) |

## Verification
The bench targets the edges of the pattern state. Each of the four run lengths must be hit exactly, which exposes an off-by-one counter that stretches or shortens every run. The gradation code must go from 4095 back to 1; a design that wrapped to 0 or stopped there would show it. A single pixel with test mode off, followed by re-entry, must restart both patterns; a design that kept its counters would go on mid-run. The bench also reverses the channel order, and drives enable high and the monitor select while the data carries odd and even bit-0 values, so that a swapped pair, leaked data while disabled, or a monitor clock in the wrong phase each produces a wrong word.

// File: rtl/afe_il_pkg.sv
package afe_il_pkg;

   typedef enum logic {
      PAT_GRADATION = 1'b0,
      PAT_STRIPE    = 1'b1
   } pat_kind_e;

   typedef enum logic {
      ORDER_EVEN_FIRST = 1'b0,
      ORDER_ODD_FIRST  = 1'b1
   } ch_order_e;

   localparam int NUM_CH = 2;

endpackage

// File: rtl/afe_il_pattern.sv
module afe_il_pattern
   import afe_il_pkg::*;
#(
   parameter int W          = 12,
   parameter int CLAMP_W    = 8,
   parameter int STRIPE_LOG = 3,
   parameter int GRAD_LOG   = 1,
   parameter int LIFT       = 128
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            step,
   input  logic                            enable,
   input  pat_kind_e                       kind,
   input  logic [1:0]                      interval,
   input  logic [NUM_CH-1:0][CLAMP_W-1:0]  clamp,
   output logic [NUM_CH-1:0][W-1:0]        pat
);

   localparam int BASE_LOG = (STRIPE_LOG > GRAD_LOG) ? STRIPE_LOG : GRAD_LOG;
   localparam int CNT_W    = BASE_LOG + 3;
   localparam logic [W-1:0] CODE_TOP   = {W{1'b1}};
   localparam logic [W-1:0] CODE_FIRST = W'(1);

   logic [CNT_W-1:0] run_cnt;
   logic [CNT_W-1:0] run_last;
   logic             raised;
   logic [W-1:0]     code;
   logic             run_done;

   always_comb begin
      if (kind == PAT_STRIPE)
         run_last = CNT_W'(((1 << STRIPE_LOG) << interval) - 1);
      else
         run_last = CNT_W'(((1 << GRAD_LOG) << interval) - 1);
   end

   assign run_done = (run_cnt >= run_last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_cnt <= '0;
         raised  <= 1'b1;
         code    <= CODE_FIRST;
      end else if (!enable) begin
         run_cnt <= '0;
         raised  <= 1'b1;
         code    <= CODE_FIRST;
      end else if (step) begin
         if (run_done) begin
            run_cnt <= '0;
            if (kind == PAT_STRIPE)
               raised <= ~raised;
            else
               code <= (code == CODE_TOP) ? CODE_FIRST : code + W'(1);
         end else begin
            run_cnt <= run_cnt + CNT_W'(1);
         end
      end
   end

   for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
      logic [W-1:0] black;
      assign black  = W'({clamp[g], 1'b0});
      assign pat[g] = (kind == PAT_STRIPE) ?
                      (raised ? black + W'(LIFT) : black) : code;
   end

endmodule

// File: rtl/afe_il_mux.sv
module afe_il_mux
   import afe_il_pkg::*;
#(
   parameter int W           = 12,
   parameter bit MON_PRESENT = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         pix_stb,
   input  ch_order_e    order,
   input  logic [W-1:0] word_e,
   input  logic [W-1:0] word_o,
   input  logic         oe_n,
   input  logic         mon_sel,
   output logic [W-1:0] out_word,
   output logic         out_valid
);

   logic [W-1:0] cur_q;
   logic [W-1:0] hold_q;
   logic         slot_q;
   logic [W-1:0] shown;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q  <= '0;
         hold_q <= '0;
         slot_q <= 1'b0;
      end else if (pix_stb) begin
         cur_q  <= (order == ORDER_ODD_FIRST) ? word_o : word_e;
         hold_q <= (order == ORDER_ODD_FIRST) ? word_e : word_o;
         slot_q <= 1'b1;
      end else begin
         cur_q  <= hold_q;
         slot_q <= 1'b0;
      end
   end

   if (MON_PRESENT) begin : g_mon
      assign shown = mon_sel ? {cur_q[W-1:1], slot_q} : cur_q;
   end else begin : g_nomon
      logic unused_mon;
      assign unused_mon = mon_sel ^ slot_q;
      assign shown      = cur_q;
   end

   assign out_valid = ~oe_n;
   assign out_word  = oe_n ? '0 : shown;

endmodule

// File: rtl/afe_dual_interleaver.sv
module afe_dual_interleaver
   import afe_il_pkg::*;
#(
   parameter int W           = 12,
   parameter int CLAMP_W     = 8,
   parameter int STRIPE_LOG  = 3,
   parameter int GRAD_LOG    = 1,
   parameter int LIFT        = 128,
   parameter bit MON_PRESENT = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               pix_stb,
   input  logic [W-1:0]       even_word,
   input  logic [W-1:0]       odd_word,
   input  logic               odd_first,
   input  logic               test_en,
   input  logic               pat_sel,
   input  logic [1:0]         pat_interval,
   input  logic [CLAMP_W-1:0] clamp_even,
   input  logic [CLAMP_W-1:0] clamp_odd,
   input  logic               oe_n,
   input  logic               mon_sel,
   output logic [W-1:0]       out_word,
   output logic               out_valid
);

   localparam int PEAK = (1 << (CLAMP_W + 1)) - 2 + LIFT;

   if (W < 2) begin : g_bad_w
      $error("afe_dual_interleaver: W must be at least 2");
   end
   if (PEAK >= (1 << W)) begin : g_bad_lift
      $error("afe_dual_interleaver: raised stripe level does not fit in W bits");
   end
   if (STRIPE_LOG < 0 || GRAD_LOG < 0) begin : g_bad_log
      $error("afe_dual_interleaver: run length logs must be non-negative");
   end

   logic [NUM_CH-1:0][W-1:0] pat;
   logic [W-1:0]             src_e;
   logic [W-1:0]             src_o;

   afe_il_pattern #(
      .W(W), .CLAMP_W(CLAMP_W), .STRIPE_LOG(STRIPE_LOG),
      .GRAD_LOG(GRAD_LOG), .LIFT(LIFT)
   ) u_pat (
      .clk      (clk),
      .rst_n    (rst_n),
      .step     (pix_stb),
      .enable   (test_en),
      .kind     (pat_kind_e'(pat_sel)),
      .interval (pat_interval),
      .clamp    ({clamp_odd, clamp_even}),
      .pat      (pat)
   );

   assign src_e = test_en ? pat[0] : even_word;
   assign src_o = test_en ? pat[1] : odd_word;

   afe_il_mux #(.W(W), .MON_PRESENT(MON_PRESENT)) u_mux (
      .clk       (clk),
      .rst_n     (rst_n),
      .pix_stb   (pix_stb),
      .order     (ch_order_e'(odd_first)),
      .word_e    (src_e),
      .word_o    (src_o),
      .oe_n      (oe_n),
      .mon_sel   (mon_sel),
      .out_word  (out_word),
      .out_valid (out_valid)
   );

endmodule

// File: rtl/afe_dual_interleaver_chk.sv
module afe_dual_interleaver_chk #(
   parameter int W       = 12,
   parameter int CLAMP_W = 8,
   parameter int LIFT    = 128
) (
   input logic               clk,
   input logic               rst_n,
   input logic               pix_stb,
   input logic [W-1:0]       even_word,
   input logic [W-1:0]       odd_word,
   input logic               odd_first,
   input logic               test_en,
   input logic               pat_sel,
   input logic [CLAMP_W-1:0] clamp_even,
   input logic [CLAMP_W-1:0] clamp_odd,
   input logic               oe_n,
   input logic               mon_sel,
   input logic [W-1:0]       out_word,
   input logic               out_valid
);

   // R1 and R2: first word of a pair follows the order bit
   assert_first_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
      pix_stb && !test_en |=>
         (oe_n || mon_sel ||
          out_word == ($past(odd_first) ? $past(odd_word) : $past(even_word))));

   // R7: disabled output reads as all zeros and not valid
   assert_hiz_R7: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n |-> (!out_valid && out_word == '0));

   assert_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !oe_n |-> out_valid);

   // R8: monitored bit 0 is high exactly in the first-word slot
   assert_mon_phase_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!oe_n && mon_sel) |-> (out_word[0] == $past(pix_stb)));

   // R5: a stripe word is one of the two levels of either channel
   assert_stripe_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(pix_stb) && $past(test_en) && $past(pat_sel) && !oe_n && !mon_sel) |->
         (out_word == W'({$past(clamp_even), 1'b0}) ||
          out_word == W'({$past(clamp_even), 1'b0}) + W'(LIFT) ||
          out_word == W'({$past(clamp_odd), 1'b0}) ||
          out_word == W'({$past(clamp_odd), 1'b0}) + W'(LIFT)));

   // R6: the gradation code is never zero
   assert_grad_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(pix_stb) && $past(test_en) && !$past(pat_sel) && !oe_n && !mon_sel) |->
         (out_word != '0));

endmodule

bind afe_dual_interleaver afe_dual_interleaver_chk #(
   .W(W), .CLAMP_W(CLAMP_W), .LIFT(LIFT)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .pix_stb    (pix_stb),
   .even_word  (even_word),
   .odd_word   (odd_word),
   .odd_first  (odd_first),
   .test_en    (test_en),
   .pat_sel    (pat_sel),
   .clamp_even (clamp_even),
   .clamp_odd  (clamp_odd),
   .oe_n       (oe_n),
   .mon_sel    (mon_sel),
   .out_word   (out_word),
   .out_valid  (out_valid)
);

// File: tb/afe_dual_interleaver_tb.sv
module afe_dual_interleaver_tb;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 150000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pix_stb = 1'b0;
   logic [11:0] even_word = '0;
   logic [11:0] odd_word = '0;
   logic        odd_first = 1'b0;
   logic        test_en = 1'b0;
   logic        pat_sel = 1'b0;
   logic [1:0]  pat_interval = 2'd0;
   logic [7:0]  clamp_even = 8'h50;
   logic [7:0]  clamp_odd = 8'h10;
   logic        oe_n = 1'b0;
   logic        mon_sel = 1'b0;
   logic [11:0] out_word;
   logic        out_valid;

   int    checks = 0;
   int    fails = 0;
   int    cycles = 0;
   string cur_req = "R9";
   logic [11:0] got_first;
   logic [11:0] got_second;

   // behavioural reference state
   logic [11:0] m_word = '0;
   logic [11:0] m_hold = '0;
   logic        m_slot = 1'b0;
   int          m_cnt = 0;
   bit          m_raised = 1'b1;
   int          m_code = 1;

   afe_dual_interleaver u_dut (
      .clk(clk), .rst_n(rst_n), .pix_stb(pix_stb),
      .even_word(even_word), .odd_word(odd_word), .odd_first(odd_first),
      .test_en(test_en), .pat_sel(pat_sel), .pat_interval(pat_interval),
      .clamp_even(clamp_even), .clamp_odd(clamp_odd), .oe_n(oe_n),
      .mon_sel(mon_sel), .out_word(out_word), .out_valid(out_valid)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) begin
      int v0, v1, len;
      if (!rst_n) begin
         m_word = '0; m_hold = '0; m_slot = 1'b0;
         m_cnt = 0; m_raised = 1'b1; m_code = 1;
      end else begin
         if (pix_stb) begin
            if (test_en) begin
               if (pat_sel) begin
                  v0 = 2 * int'(clamp_even) + (m_raised ? 128 : 0);
                  v1 = 2 * int'(clamp_odd) + (m_raised ? 128 : 0);
               end else begin
                  v0 = m_code;
                  v1 = m_code;
               end
               len = pat_sel ? (8 << pat_interval) : (2 << pat_interval);
               if (m_cnt >= len - 1) begin
                  m_cnt = 0;
                  if (pat_sel) m_raised = !m_raised;
                  else m_code = (m_code == 4095) ? 1 : m_code + 1;
               end else begin
                  m_cnt = m_cnt + 1;
               end
            end else begin
               v0 = int'(even_word);
               v1 = int'(odd_word);
            end
            m_word = odd_first ? 12'(v1) : 12'(v0);
            m_hold = odd_first ? 12'(v0) : 12'(v1);
            m_slot = 1'b1;
         end else begin
            m_word = m_hold;
            m_slot = 1'b0;
         end
         if (!test_en) begin
            m_cnt = 0; m_raised = 1'b1; m_code = 1;
         end
      end
   end

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > WATCHDOG) begin
         fails = fails + 1;
         $display("FAIL watchdog: got %0d cycles expected below %0d", cycles, WATCHDOG);
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   task automatic compare();
      logic [11:0] exp_w;
      exp_w = oe_n ? 12'd0 : (mon_sel ? {m_word[11:1], m_slot} : m_word);
      checks++;
      if (out_word !== exp_w || out_valid !== !oe_n) begin
         fails++;
         $display("FAIL %s: got word %0d valid %0b expected word %0d valid %0b",
                  cur_req, out_word, out_valid, exp_w, !oe_n);
      end
   endtask

   task automatic tick();
      @(negedge clk);
      compare();
   endtask

   task automatic pixel(input int e, input int o);
      pix_stb = 1'b1;
      even_word = 12'(e);
      odd_word = 12'(o);
      tick();
      got_first = out_word;
      pix_stb = 1'b0;
      tick();
      got_second = out_word;
   endtask

   task automatic expect_val(input string req, input int got, input int exp);
      checks++;
      if (got != exp) begin
         fails++;
         $display("FAIL %s: got %0d expected %0d", req, got, exp);
      end
   endtask

   initial begin
      // R9: reset state
      cur_req = "R9";
      repeat (4) tick();
      expect_val("R9", int'(out_word), 0);
      rst_n = 1'b1;
      tick();
      expect_val("R9", int'(out_word), 0);

      // R1: default order even then odd
      cur_req = "R1";
      for (int k = 0; k < 24; k++) pixel((k * 37 + 5) & 12'hFFF, (k * 91 + 2000) & 12'hFFF);
      pixel(12'hFFF, 12'h000);
      expect_val("R1", int'(got_first), 12'hFFF);
      expect_val("R1", int'(got_second), 0);

      // R2: odd first
      cur_req = "R2";
      odd_first = 1'b1;
      pixel(12'h123, 12'hABC);
      expect_val("R2", int'(got_first), 12'hABC);
      expect_val("R2", int'(got_second), 12'h123);
      for (int k = 0; k < 20; k++) pixel((k * 211) & 12'hFFF, (4095 - k * 13) & 12'hFFF);
      odd_first = 1'b0;

      // R7: output disabled
      cur_req = "R7";
      oe_n = 1'b1;
      for (int k = 0; k < 10; k++) pixel(12'hFFF, 12'h7FF);
      expect_val("R7", int'(out_valid), 0);
      oe_n = 1'b0;
      pixel(12'h0F0, 12'h00F);
      expect_val("R7", int'(out_valid), 1);

      // R8: converter clock on bit 0
      cur_req = "R8";
      mon_sel = 1'b1;
      pixel(12'h0F0, 12'h00F);
      expect_val("R8", int'(got_first), 12'h0F1);
      expect_val("R8", int'(got_second), 12'h00E);
      for (int k = 0; k < 10; k++) pixel(k * 3, k * 5 + 1);
      mon_sel = 1'b0;

      // R3 / R4 / R6: gradation, channel data ignored
      cur_req = "R6";
      test_en = 1'b1;
      pat_sel = 1'b0;
      pat_interval = 2'd0;
      pixel(12'hFFF, 12'hFFF);
      expect_val("R3", int'(got_first), 1);
      expect_val("R4", int'(got_second), 1);
      pixel(12'h555, 12'hAAA);
      pixel(12'h555, 12'hAAA);
      expect_val("R6", int'(got_first), 2);
      for (int k = 0; k < 40; k++) pixel(k, 4095 - k);
      for (int iv = 1; iv < 4; iv++) begin
         pat_interval = 2'(iv);
         for (int k = 0; k < 90; k++) pixel(k * 7, k * 11);
      end

      // R5: stripe, every interval, with odd order too
      cur_req = "R5";
      test_en = 1'b0;
      pixel(0, 0);
      test_en = 1'b1;
      pat_sel = 1'b1;
      pat_interval = 2'd0;
      pixel(12'hFFF, 0);
      expect_val("R5", int'(got_first), 288);
      expect_val("R5", int'(got_second), 160);
      for (int k = 0; k < 7; k++) pixel(k, k);
      pixel(0, 0);
      expect_val("R5", int'(got_first), 160);
      expect_val("R5", int'(got_second), 32);
      for (int iv = 0; iv < 4; iv++) begin
         pat_interval = 2'(iv);
         clamp_even = 8'(8'hFF - iv);
         clamp_odd = 8'(iv * 40);
         odd_first = iv[0];
         for (int k = 0; k < 150; k++) pixel(k, k);
      end
      odd_first = 1'b0;
      clamp_even = 8'h50;
      clamp_odd = 8'h10;

      // R10: re-entry restarts pattern
      cur_req = "R10";
      pat_interval = 2'd0;
      for (int k = 0; k < 3; k++) pixel(0, 0);
      test_en = 1'b0;
      pixel(12'h321, 12'h654);
      expect_val("R10", int'(got_first), 12'h321);
      test_en = 1'b1;
      pixel(0, 0);
      expect_val("R10", int'(got_first), 288);

      // R6: gradation wrap from 4095 to 1
      cur_req = "R6";
      test_en = 1'b0;
      pixel(0, 0);
      test_en = 1'b1;
      pat_sel = 1'b0;
      pat_interval = 2'd0;
      for (int p = 0; p < 8194; p++) begin
         pixel(p & 12'hFFF, 0);
         if (p == 8189) expect_val("R6", int'(got_first), 4095);
         if (p == 8190) expect_val("R6", int'(got_second), 1);
      end

      test_en = 1'b0;
      for (int k = 0; k < 4; k++) pixel(k + 100, k + 200);

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule